// File: doc/BRIEF.md
# MDIO Management Slave with Register File

This block is the station-side responder of a two-wire serial management link. It runs directly on the management clock MDC and samples MDIO on every rising edge. It decodes read and write frames and serves a 32-entry register space of 16-bit words. Because MDC is aperiodic, with no upper bound on the time between edges, the logic is purely edge-driven and has no timeout. The line is open-drain. The block therefore only produces an output value and an output enable, and it holds the enable low whenever it is not returning read data.

Registers 0–6 and 16–31 are storage words. Addresses 7–15 form a hole: a read there returns 16'hFFFF and a write there is discarded. Bit 3 of register 17 is a broadcast switch. While it is set, the block ignores the frame's device address and answers every address. A manager can then update every device on the bus with a single write.

The frame sequencer has these states:
- **HUNT**: counts consecutive ones. After at least 32 ones, a 0 moves it to **START**.
- **START**: expects a 1 and then moves to **OP_HI**. Any other bit returns it to HUNT.
- **OP_HI**, **OP_LO**: take the opcode. 10 means read and 01 means write. Any other opcode returns to HUNT.
- **PHY**: shifts in the 5-bit device address.
- **REG**: shifts in the 5-bit register address. An address miss returns to HUNT. Otherwise a read goes to **TA_RD1** and a write goes to **TA_WR1**.
- Read path: **TA_RD1** (line released), then **TA_RD2** (drive 0), then **RD_DATA** (16 bits), then back to HUNT.
- Write path: **TA_WR1** (expects 1), then **TA_WR2** (expects 0), then **WR_DATA** (16 bits, committed on the last bit), then back to HUNT. A wrong turnaround bit returns to HUNT.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A synchronous reset clears every storage register to 16'h0000, puts the sequencer in HUNT, and leaves mdio_oe low.
- R2: A write frame (start 01, opcode 01, address, turnaround 10, data MSB first) to registers 0–6 or 16–31 stores the data, and a later read returns it.
- R3: A read of registers 7–15 returns 16'hFFFF. A write to them changes no register.
- R4: With broadcast off, a frame whose 5-bit device address differs from strap_addr is ignored: mdio_oe stays low and no register changes.
- R5: While bit 3 of register 17 is 1, frames with any device address are served, both reads and writes.
- R6: On a read, mdio_oe is low during the first turnaround bit. In the second turnaround bit the block drives 0. It then drives 16 data bits, MSB first, each changing after a rising MDC edge, and releases the line after the last bit. The line is driven for exactly 17 bit times.
- R7: A write whose turnaround bits are not 10 is abandoned and changes no register.
- R8: A frame preceded by fewer than 32 consecutive ones is ignored.
- R9: A start pattern other than 01, or an opcode of 00 or 11, abandons the frame. A later frame with a proper preamble is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strap_addr | input | 5 | Device address assigned by board strapping |
| mdio_in | input | 1 | Sampled level of the MDIO line |
| mdio_out | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | Output enable for the open-drain MDIO pad |

## Verification
Write-then-read pairs with distinct patterns at the lower and upper ends of both storage ranges show that each register is kept separately. The same pairs confirm the turnaround and bit order of read responses. Writes into the hole, followed by reads of its neighbours, show the hole is both read-fixed and write-proof. Frames carrying a foreign device address, tried with broadcast off and then on, separate address filtering from broadcast acceptance. Short preambles, broken start bits, illegal opcodes and bad write turnarounds each check that one specific decode step rejects the frame, and a good frame sent afterwards shows that the sequencer recovers.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_START,
        ST_OP_HI,
        ST_OP_LO,
        ST_PHY,
        ST_REG,
        ST_TA_RD1,
        ST_TA_RD2,
        ST_RD_DATA,
        ST_TA_WR1,
        ST_TA_WR2,
        ST_WR_DATA
    } mdio_state_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int HOLE_LO   = 7,
    parameter int HOLE_HI   = 15,
    parameter int BCAST_REG = 17,
    parameter int BCAST_BIT = 3,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              mdc,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              bcast_en
);

    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] word [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_word
        if (i >= HOLE_LO && i <= HOLE_HI) begin : g_hole
            // Unimplemented slot: constant all-ones, writes dropped.
            assign word[i] = '1;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge mdc) begin
                if (rst) begin
                    q <= RESET_VAL;
                end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                    q <= wr_data;
                end
            end
            assign word[i] = q;
        end
    end

    assign rd_data  = word[rd_addr];
    assign bcast_en = word[BCAST_REG][BCAST_BIT];

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_slave_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_MIN = 32
) (
    input  logic              mdc,
    input  logic              rst,
    input  logic              mdio_in,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              bcast_en,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_out,
    output logic              mdio_oe
);

    localparam int PRE_W = $clog2(PRE_MIN + 1);
    localparam int CNT_W = (DATA_W > ADDR_W) ? $clog2(DATA_W) : $clog2(ADDR_W);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    mdio_state_e       state, state_nx;
    logic [PRE_W-1:0]  pre_cnt;
    logic [CNT_W-1:0]  bit_cnt;
    logic              op_hi;
    logic              op_rd;
    logic [ADDR_W-1:0] phy_sh;
    logic [ADDR_W-1:0] reg_sh;
    logic [DATA_W-1:0] shreg;
    logic              pre_ok;
    logic              addr_hit;

    assign pre_ok   = (pre_cnt >= PRE_W'(PRE_MIN));
    assign addr_hit = bcast_en || (phy_sh == strap_addr);

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:    if (!mdio_in && pre_ok) state_nx = ST_START;
            ST_START:   state_nx = mdio_in ? ST_OP_HI : ST_HUNT;
            ST_OP_HI:   state_nx = ST_OP_LO;
            ST_OP_LO: begin
                if ({op_hi, mdio_in} == OPC_READ || {op_hi, mdio_in} == OPC_WRITE)
                    state_nx = ST_PHY;
                else
                    state_nx = ST_HUNT;
            end
            ST_PHY:     if (bit_cnt == ADDR_LAST) state_nx = ST_REG;
            ST_REG: begin
                if (bit_cnt == ADDR_LAST) begin
                    if (!addr_hit)  state_nx = ST_HUNT;
                    else if (op_rd) state_nx = ST_TA_RD1;
                    else            state_nx = ST_TA_WR1;
                end
            end
            ST_TA_RD1:  state_nx = ST_TA_RD2;
            ST_TA_RD2:  state_nx = ST_RD_DATA;
            ST_RD_DATA: if (bit_cnt == '0) state_nx = ST_HUNT;
            ST_TA_WR1:  state_nx = mdio_in ? ST_TA_WR2 : ST_HUNT;
            ST_TA_WR2:  state_nx = mdio_in ? ST_HUNT : ST_WR_DATA;
            ST_WR_DATA: if (bit_cnt == DATA_LAST) state_nx = ST_HUNT;
            default:    state_nx = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge mdc) begin
        if (rst) state <= ST_HUNT;
        else     state <= state_nx;
    end

    // Frame datapath: counters and shift registers
    always_ff @(posedge mdc) begin
        if (rst) begin
            pre_cnt <= '0;
            bit_cnt <= '0;
            op_hi   <= 1'b0;
            op_rd   <= 1'b0;
            phy_sh  <= '0;
            reg_sh  <= '0;
            shreg   <= '0;
        end else begin
            if (state == ST_HUNT && mdio_in) begin
                if (!pre_ok) pre_cnt <= pre_cnt + 1'b1;
            end else begin
                pre_cnt <= '0;
            end
            unique case (state)
                ST_OP_HI: op_hi <= mdio_in;
                ST_OP_LO: begin
                    op_rd   <= op_hi & ~mdio_in;
                    bit_cnt <= '0;
                end
                ST_PHY: begin
                    phy_sh  <= {phy_sh[ADDR_W-2:0], mdio_in};
                    bit_cnt <= (bit_cnt == ADDR_LAST) ? '0 : bit_cnt + 1'b1;
                end
                ST_REG: begin
                    reg_sh  <= {reg_sh[ADDR_W-2:0], mdio_in};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                ST_TA_RD1: begin
                    shreg   <= rd_data;
                    bit_cnt <= DATA_LAST;
                end
                ST_RD_DATA: bit_cnt <= bit_cnt - 1'b1;
                ST_TA_WR2:  bit_cnt <= '0;
                ST_WR_DATA: begin
                    shreg   <= {shreg[DATA_W-2:0], mdio_in};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        reg_addr = reg_sh;
        wr_en    = (state == ST_WR_DATA) && (bit_cnt == DATA_LAST) && !rst;
        wr_data  = {shreg[DATA_W-2:0], mdio_in};
        mdio_oe  = (state == ST_TA_RD2) || (state == ST_RD_DATA);
        mdio_out = (state == ST_RD_DATA) ? shreg[bit_cnt] : 1'b0;
    end

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int PRE_MIN   = 32,
    parameter int HOLE_LO   = 7,
    parameter int HOLE_HI   = 15,
    parameter int BCAST_REG = 17,
    parameter int BCAST_BIT = 3
) (
    input  logic              mdc,
    input  logic              rst,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe
);

    logic [ADDR_W-1:0] reg_addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              bcast_en;

    mdio_frame_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PRE_MIN(PRE_MIN)
    ) fsm_i (
        .mdc       (mdc),
        .rst       (rst),
        .mdio_in   (mdio_in),
        .strap_addr(strap_addr),
        .bcast_en  (bcast_en),
        .rd_data   (rd_data),
        .reg_addr  (reg_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );

    mdio_regfile #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .HOLE_LO  (HOLE_LO),
        .HOLE_HI  (HOLE_HI),
        .BCAST_REG(BCAST_REG),
        .BCAST_BIT(BCAST_BIT)
    ) regs_i (
        .mdc     (mdc),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (reg_addr),
        .wr_data (wr_data),
        .rd_addr (reg_addr),
        .rd_data (rd_data),
        .bcast_en(bcast_en)
    );

endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk #(
    parameter int PRE_MIN = 32,
    parameter int DATA_W  = 16
) (
    input logic mdc,
    input logic rst,
    input logic mdio_in,
    input logic mdio_out,
    input logic mdio_oe
);

    localparam int PRE_W = $clog2(PRE_MIN + 1);
    localparam int RUN_W = $clog2(DATA_W + 3);

    logic [PRE_W-1:0] ones_cnt;
    logic             saw_pre;
    logic [RUN_W-1:0] oe_run;
    logic             rst_q;

    always_ff @(posedge mdc) begin
        rst_q <= rst;
        if (rst) begin
            ones_cnt <= '0;
            saw_pre  <= 1'b0;
            oe_run   <= '0;
        end else begin
            if (!mdio_in)                          ones_cnt <= '0;
            else if (ones_cnt != PRE_W'(PRE_MIN))  ones_cnt <= ones_cnt + 1'b1;
            if (ones_cnt == PRE_W'(PRE_MIN))       saw_pre  <= 1'b1;
            if (mdio_oe && oe_run != '1)           oe_run   <= oe_run + 1'b1;
            else if (!mdio_oe)                     oe_run   <= '0;
        end
    end

    // R1: line released in the cycle after reset
    assert_release_reset_R1: assert property (@(posedge mdc)
        rst_q && !rst |-> !mdio_oe);

    // R6: the first driven bit is the turnaround zero
    assert_ta_zero_R6: assert property (@(posedge mdc) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_out);

    // R6: drive window is turnaround plus data, no more
    assert_read_len_R6: assert property (@(posedge mdc) disable iff (rst)
        $fell(mdio_oe) && !rst_q |-> oe_run == RUN_W'(DATA_W + 1));

    // R8: no response without a full preamble seen earlier
    assert_preamble_first_R8: assert property (@(posedge mdc) disable iff (rst)
        $rose(mdio_oe) |-> saw_pre);

endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(
    .PRE_MIN(PRE_MIN),
    .DATA_W (DATA_W)
) chk_i (
    .mdc     (mdc),
    .rst     (rst),
    .mdio_in (mdio_in),
    .mdio_out(mdio_out),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb_top;

    localparam logic [4:0] STRAP = 5'h0A;

    logic       mdc = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] strap_addr = STRAP;
    logic       mdio_in = 1'b1;
    logic       mdio_out;
    logic       mdio_oe;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [32];

    always #2.5 mdc = ~mdc;

    mdio_mgmt_slave dut_i (
        .mdc       (mdc),
        .rst       (rst),
        .strap_addr(strap_addr),
        .mdio_in   (mdio_in),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        @(negedge mdc);
        mdio_in = b;
    endtask

    task automatic send_field(input logic [15:0] v, input int w);
        for (int i = w - 1; i >= 0; i--) drive_bit(v[i]);
    endtask

    task automatic send_pre(input int n);
        for (int i = 0; i < n; i++) drive_bit(1'b1);
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] d, input logic [1:0] ta);
        send_pre(32);
        send_field(16'b01, 2);
        send_field(16'b01, 2);
        send_field({11'd0, phy}, 5);
        send_field({11'd0, ra}, 5);
        send_field({14'd0, ta}, 2);
        send_field(d, 16);
        drive_bit(1'b1);
    endtask

    // Runs the read response window; proto_ok = exact turnaround/release, drove = any drive
    task automatic read_window(output logic [15:0] v, output bit proto_ok, output bit drove);
        v = '0; proto_ok = 1; drove = 0;
        @(negedge mdc); mdio_in = 1'b1;
        if (mdio_oe) begin proto_ok = 0; drove = 1; end
        @(negedge mdc);
        if (!(mdio_oe && !mdio_out)) proto_ok = 0;
        if (mdio_oe) drove = 1;
        for (int i = 0; i < 16; i++) begin
            @(negedge mdc);
            if (!mdio_oe) proto_ok = 0; else drove = 1;
            v = {v[14:0], mdio_out};
        end
        @(negedge mdc);
        if (mdio_oe) begin proto_ok = 0; drove = 1; end
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] ra,
                           output logic [15:0] v, output bit proto_ok, output bit drove);
        send_pre(32);
        send_field(16'b01, 2);
        send_field(16'b10, 2);
        send_field({11'd0, phy}, 5);
        send_field({11'd0, ra}, 5);
        read_window(v, proto_ok, drove);
    endtask

    task automatic read_expect(input logic [4:0] ra, input logic [15:0] exp, input string req);
        logic [15:0] v; bit ok; bit drv;
        do_read(STRAP, ra, v, ok, drv);
        check(ok, "R6 read turnaround/length", {15'd0, ok}, 16'd1);
        check(v == exp, req, v, exp);
    endtask

    task automatic t_reset();
        @(negedge mdc);
        check(!mdio_oe, "R1 oe after reset", {15'd0, mdio_oe}, 16'd0);
        read_expect(5'd0, 16'h0000, "R1 reg0 reset");
        read_expect(5'd16, 16'h0000, "R1 reg16 reset");
        read_expect(5'd31, 16'h0000, "R1 reg31 reset");
    endtask

    task automatic t_rw();
        logic [4:0] regs [5] = '{5'd0, 5'd6, 5'd16, 5'd17, 5'd31};
        logic [15:0] pats [5] = '{16'hA5C3, 16'h8001, 16'h7FFE, 16'hA5A1, 16'h1234};
        for (int i = 0; i < 5; i++) begin
            do_write(STRAP, regs[i], pats[i], 2'b10);
            model[regs[i]] = pats[i];
        end
        for (int i = 0; i < 5; i++) read_expect(regs[i], model[regs[i]], "R2 write/read");
    endtask

    task automatic t_hole();
        do_write(STRAP, 5'd7, 16'h1357, 2'b10);
        do_write(STRAP, 5'd15, 16'h2468, 2'b10);
        read_expect(5'd7, 16'hFFFF, "R3 reg7 reads ones");
        read_expect(5'd15, 16'hFFFF, "R3 reg15 reads ones");
        read_expect(5'd11, 16'hFFFF, "R3 reg11 reads ones");
        read_expect(5'd6, model[6], "R3 neighbour 6 intact");
        read_expect(5'd16, model[16], "R3 neighbour 16 intact");
    endtask

    task automatic t_mismatch();
        logic [15:0] v; bit ok; bit drv;
        do_read(5'h03, 5'd0, v, ok, drv);
        check(!drv, "R4 foreign read not driven", {15'd0, drv}, 16'd0);
        do_write(5'h03, 5'd0, 16'hDEAD, 2'b10);
        read_expect(5'd0, model[0], "R4 foreign write ignored");
    endtask

    task automatic t_bcast();
        logic [15:0] v; bit ok; bit drv;
        do_write(STRAP, 5'd17, 16'h0008, 2'b10);
        model[17] = 16'h0008;
        do_read(5'h1F, 5'd17, v, ok, drv);
        check(ok && v == 16'h0008, "R5 broadcast read any address", v, 16'h0008);
        do_write(5'h05, 5'd1, 16'hBEEF, 2'b10);
        model[1] = 16'hBEEF;
        read_expect(5'd1, 16'hBEEF, "R5 broadcast write any address");
        do_write(5'h11, 5'd17, 16'h0000, 2'b10);
        model[17] = 16'h0000;
        do_read(5'h11, 5'd17, v, ok, drv);
        check(!drv, "R5 broadcast cleared, foreign ignored", {15'd0, drv}, 16'd0);
    endtask

    task automatic t_turnaround();
        do_write(STRAP, 5'd2, 16'h1111, 2'b11);
        do_write(STRAP, 5'd2, 16'h2222, 2'b00);
        read_expect(5'd2, model[2], "R7 bad turnaround discarded");
    endtask

    task automatic t_short_pre();
        logic [15:0] v; bit ok; bit drv;
        drive_bit(1'b0);
        send_pre(31);
        send_field(16'b0110, 4);
        send_field({11'd0, STRAP}, 5);
        send_field(16'd0, 5);
        read_window(v, ok, drv);
        check(!drv, "R8 short preamble read ignored", {15'd0, drv}, 16'd0);
        drive_bit(1'b0);
        send_pre(31);
        send_field(16'b0101, 4);
        send_field({11'd0, STRAP}, 5);
        send_field(16'd3, 5);
        send_field(16'b10, 2);
        send_field(16'hCAFE, 16);
        drive_bit(1'b1);
        read_expect(5'd3, model[3], "R8 short preamble write ignored");
    endtask

    task automatic t_bad_frame();
        logic [15:0] v; bit ok; bit drv;
        // bad start 00 followed by a read-shaped tail
        send_pre(32);
        send_field(16'b0010, 4);
        send_field({11'd0, STRAP}, 5);
        send_field(16'd0, 5);
        read_window(v, ok, drv);
        check(!drv, "R9 bad start abandoned", {15'd0, drv}, 16'd0);
        // opcode 11 and 00 with write-shaped tails
        for (int k = 0; k < 2; k++) begin
            send_pre(32);
            send_field(16'b01, 2);
            send_field(k == 0 ? 16'b11 : 16'b00, 2);
            send_field({11'd0, STRAP}, 5);
            send_field(16'd4, 5);
            send_field(16'b10, 2);
            send_field(16'h0F0F, 16);
            drive_bit(1'b1);
        end
        read_expect(5'd4, model[4], "R9 bad opcode abandoned, recovery");
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = (i >= 7 && i <= 15) ? 16'hFFFF : 16'h0000;
        repeat (4) @(negedge mdc);
        rst = 1'b0;
        t_reset();
        t_rw();
        t_hole();
        t_mismatch();
        t_bcast();
        t_turnaround();
        t_short_pre();
        t_bad_frame();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge mdc);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule